// File: doc/BRIEF.md
# Redundant Stream Duplicate Eliminator

This block sits behind two receive paths, A and B, that carry identical virtual-link traffic over independent networks. Each path hands it one pre-validated frame descriptor per cycle at most: a link index and a sequence number. The block forwards each logical frame once and throws away its twin.

The block keeps one record per link. The record holds a valid bit, the sequence number it last forwarded and the microsecond time of that forward. An incoming descriptor is a duplicate when three things hold: the record is valid, the sequence number matches, and the time since the last forward is no more than a run-time skew limit. A duplicate is dropped. Any other descriptor is forwarded and overwrites the record.

Each lane returns its verdict one cycle after its input. A lane either forwards the descriptor with its link index, so downstream logic can place it in that link's queue, or it raises a drop pulse.

Top module: `dup_eliminator`

## Requirements
- R1: During and right after synchronous reset, every forward and drop output is low, and every link record is invalid.
- R2: The first descriptor seen on a link after reset is forwarded, whatever its sequence number.
- R3: A descriptor is dropped when its link record is valid, its sequence number equals the recorded one, and the elapsed time since that record was written is at most `cfg_skew_us` microseconds. Its drop output pulses and its forward output stays low.
- R4: A descriptor that matches the recorded sequence number but arrives after more than `cfg_skew_us` microseconds is forwarded as a new frame, and the record's time is refreshed.
- R5: A descriptor whose sequence number differs from the recorded one is forwarded and becomes the new record for its link.
- R6: Records are independent per link. A descriptor on one link neither reads nor changes another link's record.
- R7: When both lanes present a descriptor in the same cycle, lane A is judged first. Lane B is judged against the record as lane A left it. If both forward on the same link, lane B's values are the ones stored.
- R8: Each lane's outputs appear exactly one clock after its input valid. The forwarded link index and sequence number equal the input's. Cycles without an input valid produce neither a forward nor a drop.
- R9: Elapsed time is the current microsecond count minus the recorded time, taken modulo 2^TW, so a window that spans a wrap of the counter is judged correctly.
- R10: `cfg_skew_us` is read every cycle and may change at run time. Its width TW (default 16) lets it reach well past 500 microseconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_skew_us | input | TW | Maximum skew between copies, in microseconds |
| in_a_valid | input | 1 | Lane A descriptor present |
| in_a_link | input | LINKW | Lane A link index |
| in_a_seq | input | SEQW | Lane A sequence number |
| in_b_valid | input | 1 | Lane B descriptor present |
| in_b_link | input | LINKW | Lane B link index |
| in_b_seq | input | SEQW | Lane B sequence number |
| fwd_a_valid | output | 1 | Lane A descriptor forwarded |
| fwd_a_link | output | LINKW | Lane A forwarded link index |
| fwd_a_seq | output | SEQW | Lane A forwarded sequence number |
| drop_a | output | 1 | Lane A descriptor discarded as duplicate |
| fwd_b_valid | output | 1 | Lane B descriptor forwarded |
| fwd_b_link | output | LINKW | Lane B forwarded link index |
| fwd_b_seq | output | SEQW | Lane B forwarded sequence number |
| drop_b | output | 1 | Lane B descriptor discarded as duplicate |

## Verification
The assertions assume each input link index is below NLINK and that inputs are steady around the clock edge. They also rely on the same-cycle, same-link, same-sequence case always dropping on lane B, which follows from the zero elapsed time after lane A's forward. The stimulus drives only legal link indices on the falling edge. It spaces each duplicate pair well inside or well outside the skew window, with several microsecond ticks of margin, so prescaler phase cannot move a verdict. The wrap case places its first copy shortly before the counter rolls over.

// File: rtl/dup_elim_pkg.sv
package dup_elim_pkg;

  typedef enum logic [1:0] {
    VERD_IDLE = 2'd0,
    VERD_FWD  = 2'd1,
    VERD_DROP = 2'd2
  } verdict_e;

  localparam int NUM_LANES = 2;

endpackage

// File: rtl/dup_elim_usec_timer.sv
module dup_elim_usec_timer #(
  parameter int CYC_PER_US = 100,
  parameter int TW         = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] now_us
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre    <= '0;
      now_us <= '0;
    end else if (pre == PRE_LAST) begin
      pre    <= '0;
      now_us <= now_us + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/dup_elim_link_table.sv
module dup_elim_link_table #(
  parameter int NLINK = 16,
  parameter int SEQW  = 8,
  parameter int TW    = 16,
  localparam int LINKW = $clog2(NLINK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINKW-1:0] rd_a_link,
  output logic             rd_a_vld,
  output logic [SEQW-1:0]  rd_a_seq,
  output logic [TW-1:0]    rd_a_time,
  input  logic [LINKW-1:0] rd_b_link,
  output logic             rd_b_vld,
  output logic [SEQW-1:0]  rd_b_seq,
  output logic [TW-1:0]    rd_b_time,
  input  logic             wr_a_en,
  input  logic [LINKW-1:0] wr_a_link,
  input  logic [SEQW-1:0]  wr_a_seq,
  input  logic [TW-1:0]    wr_a_time,
  input  logic             wr_b_en,
  input  logic [LINKW-1:0] wr_b_link,
  input  logic [SEQW-1:0]  wr_b_seq,
  input  logic [TW-1:0]    wr_b_time
);
  logic [NLINK-1:0] vld_bits;
  logic [SEQW-1:0]  seq_mem  [NLINK];
  logic [TW-1:0]    time_mem [NLINK];

  // Valid bits need reset; the payload arrays do not, so they can map to RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_bits <= '0;
    end else begin
      if (wr_a_en) vld_bits[wr_a_link] <= 1'b1;
      if (wr_b_en) vld_bits[wr_b_link] <= 1'b1;
    end
  end

  // Lane B is written last so it wins a same-link collision.
  always_ff @(posedge clk) begin
    if (wr_a_en) begin
      seq_mem[wr_a_link]  <= wr_a_seq;
      time_mem[wr_a_link] <= wr_a_time;
    end
    if (wr_b_en) begin
      seq_mem[wr_b_link]  <= wr_b_seq;
      time_mem[wr_b_link] <= wr_b_time;
    end
  end

  assign rd_a_vld  = vld_bits[rd_a_link];
  assign rd_a_seq  = seq_mem[rd_a_link];
  assign rd_a_time = time_mem[rd_a_link];
  assign rd_b_vld  = vld_bits[rd_b_link];
  assign rd_b_seq  = seq_mem[rd_b_link];
  assign rd_b_time = time_mem[rd_b_link];
endmodule

// File: rtl/dup_elim_judge.sv
module dup_elim_judge
  import dup_elim_pkg::*;
#(
  parameter int SEQW = 8,
  parameter int TW   = 16
) (
  input  logic            in_vld,
  input  logic [SEQW-1:0] in_seq,
  input  logic            rec_vld,
  input  logic [SEQW-1:0] rec_seq,
  input  logic [TW-1:0]   rec_time,
  input  logic [TW-1:0]   now_us,
  input  logic [TW-1:0]   skew_us,
  output verdict_e        verdict
);
  logic [TW-1:0] elapsed;
  logic          is_dup;

  // Modulo 2^TW difference stays correct across a counter wrap.
  assign elapsed = now_us - rec_time;
  assign is_dup  = rec_vld && (in_seq == rec_seq) && (elapsed <= skew_us);

  always_comb begin
    if (!in_vld)     verdict = VERD_IDLE;
    else if (is_dup) verdict = VERD_DROP;
    else             verdict = VERD_FWD;
  end
endmodule

// File: rtl/dup_eliminator.sv
module dup_eliminator
  import dup_elim_pkg::*;
#(
  parameter int NLINK      = 16,
  parameter int SEQW       = 8,
  parameter int TW         = 16,
  parameter int CYC_PER_US = 100,
  localparam int LINKW = $clog2(NLINK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    cfg_skew_us,
  input  logic             in_a_valid,
  input  logic [LINKW-1:0] in_a_link,
  input  logic [SEQW-1:0]  in_a_seq,
  input  logic             in_b_valid,
  input  logic [LINKW-1:0] in_b_link,
  input  logic [SEQW-1:0]  in_b_seq,
  output logic             fwd_a_valid,
  output logic [LINKW-1:0] fwd_a_link,
  output logic [SEQW-1:0]  fwd_a_seq,
  output logic             drop_a,
  output logic             fwd_b_valid,
  output logic [LINKW-1:0] fwd_b_link,
  output logic [SEQW-1:0]  fwd_b_seq,
  output logic             drop_b
);
  logic [TW-1:0] now_us;

  logic             ln_vld  [NUM_LANES];
  logic [LINKW-1:0] ln_link [NUM_LANES];
  logic [SEQW-1:0]  ln_seq  [NUM_LANES];
  logic             rec_vld [NUM_LANES];
  logic [SEQW-1:0]  rec_seq [NUM_LANES];
  logic [TW-1:0]    rec_time[NUM_LANES];
  logic             tb_vld  [NUM_LANES];
  logic [SEQW-1:0]  tb_seq  [NUM_LANES];
  logic [TW-1:0]    tb_time [NUM_LANES];
  verdict_e         verd    [NUM_LANES];
  logic             o_fwd   [NUM_LANES];
  logic             o_drop  [NUM_LANES];
  logic [LINKW-1:0] o_link  [NUM_LANES];
  logic [SEQW-1:0]  o_seq   [NUM_LANES];

  assign ln_vld[0]  = in_a_valid;
  assign ln_link[0] = in_a_link;
  assign ln_seq[0]  = in_a_seq;
  assign ln_vld[1]  = in_b_valid;
  assign ln_link[1] = in_b_link;
  assign ln_seq[1]  = in_b_seq;

  dup_elim_usec_timer #(.CYC_PER_US(CYC_PER_US), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .now_us(now_us)
  );

  dup_elim_link_table #(.NLINK(NLINK), .SEQW(SEQW), .TW(TW)) u_table (
    .clk(clk), .rst(rst),
    .rd_a_link(ln_link[0]), .rd_a_vld(tb_vld[0]), .rd_a_seq(tb_seq[0]), .rd_a_time(tb_time[0]),
    .rd_b_link(ln_link[1]), .rd_b_vld(tb_vld[1]), .rd_b_seq(tb_seq[1]), .rd_b_time(tb_time[1]),
    .wr_a_en(verd[0] == VERD_FWD), .wr_a_link(ln_link[0]), .wr_a_seq(ln_seq[0]), .wr_a_time(now_us),
    .wr_b_en(verd[1] == VERD_FWD), .wr_b_link(ln_link[1]), .wr_b_seq(ln_seq[1]), .wr_b_time(now_us)
  );

  // Lane A sees the stored record; lane B sees it after lane A's update.
  always_comb begin
    rec_vld[0]  = tb_vld[0];
    rec_seq[0]  = tb_seq[0];
    rec_time[0] = tb_time[0];
    if (verd[0] == VERD_FWD && ln_link[0] == ln_link[1]) begin
      rec_vld[1]  = 1'b1;
      rec_seq[1]  = ln_seq[0];
      rec_time[1] = now_us;
    end else begin
      rec_vld[1]  = tb_vld[1];
      rec_seq[1]  = tb_seq[1];
      rec_time[1] = tb_time[1];
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    dup_elim_judge #(.SEQW(SEQW), .TW(TW)) u_judge (
      .in_vld(ln_vld[g]), .in_seq(ln_seq[g]),
      .rec_vld(rec_vld[g]), .rec_seq(rec_seq[g]), .rec_time(rec_time[g]),
      .now_us(now_us), .skew_us(cfg_skew_us), .verdict(verd[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        o_fwd[g]  <= 1'b0;
        o_drop[g] <= 1'b0;
        o_link[g] <= '0;
        o_seq[g]  <= '0;
      end else begin
        o_fwd[g]  <= (verd[g] == VERD_FWD);
        o_drop[g] <= (verd[g] == VERD_DROP);
        if (ln_vld[g]) begin
          o_link[g] <= ln_link[g];
          o_seq[g]  <= ln_seq[g];
        end
      end
    end
  end

  assign fwd_a_valid = o_fwd[0];
  assign fwd_a_link  = o_link[0];
  assign fwd_a_seq   = o_seq[0];
  assign drop_a      = o_drop[0];
  assign fwd_b_valid = o_fwd[1];
  assign fwd_b_link  = o_link[1];
  assign fwd_b_seq   = o_seq[1];
  assign drop_b      = o_drop[1];
endmodule

// File: rtl/dup_eliminator_chk.sv
module dup_eliminator_chk #(
  parameter int LINKW = 4,
  parameter int SEQW  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_a_valid,
  input logic [LINKW-1:0] in_a_link,
  input logic [SEQW-1:0]  in_a_seq,
  input logic             in_b_valid,
  input logic [LINKW-1:0] in_b_link,
  input logic [SEQW-1:0]  in_b_seq,
  input logic             fwd_a_valid,
  input logic [LINKW-1:0] fwd_a_link,
  input logic             drop_a,
  input logic             fwd_b_valid,
  input logic [SEQW-1:0]  fwd_b_seq,
  input logic             drop_b
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst_d |-> !fwd_a_valid && !fwd_b_valid && !drop_a && !drop_b);

  p_verdict_excl_a_r3: assert property (@(posedge clk) disable iff (rst)
    !(fwd_a_valid && drop_a));

  p_verdict_excl_b_r3: assert property (@(posedge clk) disable iff (rst)
    !(fwd_b_valid && drop_b));

  p_one_cycle_a_r8: assert property (@(posedge clk) disable iff (rst)
    in_a_valid |=> (fwd_a_valid || drop_a));

  p_one_cycle_b_r8: assert property (@(posedge clk) disable iff (rst)
    in_b_valid |=> (fwd_b_valid || drop_b));

  p_idle_silent_r8: assert property (@(posedge clk) disable iff (rst)
    !in_a_valid && !in_b_valid |=> !fwd_a_valid && !drop_a && !fwd_b_valid && !drop_b);

  p_link_echo_r8: assert property (@(posedge clk) disable iff (rst)
    in_a_valid |=> fwd_a_link == $past(in_a_link));

  p_seq_echo_r8: assert property (@(posedge clk) disable iff (rst)
    in_b_valid |=> fwd_b_seq == $past(in_b_seq));

  p_twin_dropped_r7: assert property (@(posedge clk) disable iff (rst)
    in_a_valid && in_b_valid && in_a_link == in_b_link && in_a_seq == in_b_seq |=> drop_b);
endmodule

bind dup_eliminator dup_eliminator_chk #(.LINKW(LINKW), .SEQW(SEQW)) u_chk (
  .clk(clk), .rst(rst),
  .in_a_valid(in_a_valid), .in_a_link(in_a_link), .in_a_seq(in_a_seq),
  .in_b_valid(in_b_valid), .in_b_link(in_b_link), .in_b_seq(in_b_seq),
  .fwd_a_valid(fwd_a_valid), .fwd_a_link(fwd_a_link), .drop_a(drop_a),
  .fwd_b_valid(fwd_b_valid), .fwd_b_seq(fwd_b_seq), .drop_b(drop_b)
);

// File: tb/sim_dup_eliminator.sv
module sim_dup_eliminator;
  localparam int CLK_PERIOD = 10;
  localparam int NLINK = 8;
  localparam int SEQW  = 8;
  localparam int TW    = 8;
  localparam int CPU   = 2;
  localparam int LINKW = $clog2(NLINK);
  localparam int WRAP_CYC = (1 << TW) * CPU;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] cfg_skew_us = 8'd20;
  logic in_a_valid = 1'b0, in_b_valid = 1'b0;
  logic [LINKW-1:0] in_a_link = '0, in_b_link = '0;
  logic [SEQW-1:0] in_a_seq = '0, in_b_seq = '0;
  logic fwd_a_valid, fwd_b_valid, drop_a, drop_b;
  logic [LINKW-1:0] fwd_a_link, fwd_b_link;
  logic [SEQW-1:0] fwd_a_seq, fwd_b_seq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  dup_eliminator #(.NLINK(NLINK), .SEQW(SEQW), .TW(TW), .CYC_PER_US(CPU)) u0 (
    .clk(clk), .rst(rst), .cfg_skew_us(cfg_skew_us),
    .in_a_valid(in_a_valid), .in_a_link(in_a_link), .in_a_seq(in_a_seq),
    .in_b_valid(in_b_valid), .in_b_link(in_b_link), .in_b_seq(in_b_seq),
    .fwd_a_valid(fwd_a_valid), .fwd_a_link(fwd_a_link), .fwd_a_seq(fwd_a_seq), .drop_a(drop_a),
    .fwd_b_valid(fwd_b_valid), .fwd_b_link(fwd_b_link), .fwd_b_seq(fwd_b_seq), .drop_b(drop_b)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive on a falling edge, sample one falling edge later (one register).
  task automatic send(input bit av, input int al, input int as_,
                      input bit bv, input int bl, input int bs);
    @(negedge clk);
    in_a_valid = av; in_a_link = LINKW'(al); in_a_seq = SEQW'(as_);
    in_b_valid = bv; in_b_link = LINKW'(bl); in_b_seq = SEQW'(bs);
    @(negedge clk);
    in_a_valid = 1'b0; in_b_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 fwd_a after reset", fwd_a_valid, 0);
    check("R1 fwd_b after reset", fwd_b_valid, 0);
    check("R1 drops after reset", drop_a | drop_b, 0);
    idle(3);
    check("R8 idle gives no output", fwd_a_valid | fwd_b_valid | drop_a | drop_b, 0);
  endtask

  task automatic t_first;
    send(1, 1, 5, 0, 0, 0);
    check("R2 first frame forwarded", fwd_a_valid, 1);
    check("R8 forwarded link", fwd_a_link, 1);
    check("R8 forwarded seq", fwd_a_seq, 5);
    check("R1 record invalid so drop low", drop_a, 0);
  endtask

  task automatic t_dup_window;
    idle(10);
    send(0, 0, 0, 1, 1, 5);
    check("R3 duplicate dropped", drop_b, 1);
    check("R3 duplicate not forwarded", fwd_b_valid, 0);
  endtask

  task automatic t_new_seq;
    send(1, 1, 6, 0, 0, 0);
    check("R5 new seq forwarded", fwd_a_valid, 1);
    idle(4);
    send(0, 0, 0, 1, 1, 6);
    check("R5 record updated, copy dropped", drop_b, 1);
    send(0, 0, 0, 1, 1, 5);
    check("R5 old seq now forwarded", fwd_b_valid, 1);
  endtask

  task automatic t_expire;
    send(1, 2, 9, 0, 0, 0);
    check("R4 initial forward", fwd_a_valid, 1);
    idle(100);
    send(0, 0, 0, 1, 2, 9);
    check("R4 late copy forwarded", fwd_b_valid, 1);
    idle(4);
    send(1, 2, 9, 0, 0, 0);
    check("R4 time refreshed, next copy dropped", drop_a, 1);
  endtask

  task automatic t_per_link;
    send(1, 5, 1, 1, 6, 1);
    check("R6 link5 forwarded", fwd_a_valid, 1);
    check("R6 link6 forwarded", fwd_b_valid, 1);
    send(1, 6, 1, 1, 5, 1);
    check("R6 link6 copy dropped", drop_a, 1);
    check("R6 link5 copy dropped", drop_b, 1);
    send(1, 4, 1, 0, 0, 0);
    check("R6 untouched link4 forwarded", fwd_a_valid, 1);
  endtask

  task automatic t_same_cycle;
    send(1, 7, 3, 1, 7, 3);
    check("R7 lane A forwarded", fwd_a_valid, 1);
    check("R7 lane B twin dropped", drop_b, 1);
    send(1, 0, 4, 1, 0, 5);
    check("R7 A differing seq forwarded", fwd_a_valid, 1);
    check("R7 B differing seq forwarded", fwd_b_valid, 1);
    send(0, 0, 0, 1, 0, 5);
    check("R7 B value stored last", drop_b, 1);
    send(1, 0, 4, 0, 0, 0);
    check("R7 A value overwritten", fwd_a_valid, 1);
  endtask

  task automatic t_wrap;
    while ((cyc % WRAP_CYC) != WRAP_CYC - 22) @(negedge clk);
    send(1, 3, 20, 0, 0, 0);
    check("R9 forward before wrap", fwd_a_valid, 1);
    idle(30);
    send(0, 0, 0, 1, 3, 20);
    check("R9 copy across wrap dropped", drop_b, 1);
  endtask

  task automatic t_skew_cfg;
    cfg_skew_us = 8'd2;
    send(1, 2, 30, 0, 0, 0);
    check("R10 forward", fwd_a_valid, 1);
    idle(10);
    send(0, 0, 0, 1, 2, 30);
    check("R10 short skew forwards copy", fwd_b_valid, 1);
    cfg_skew_us = 8'd20;
    idle(4);
    send(1, 2, 30, 0, 0, 0);
    check("R10 long skew drops copy", drop_a, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_first();
    t_dup_window();
    t_new_seq();
    t_expire();
    t_per_link();
    t_same_cycle();
    t_wrap();
    t_skew_cfg();
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule